// File: doc/BRIEF.md
# Sprite Pattern Address Fetcher

This block scans a table of sprite descriptors kept in a byte-addressed video memory with 4 bits per pixel. A start pulse begins a pass. For each of the 125 descriptors the block issues four single-byte reads and records the vertical position, the pattern number, the horizontal position and the attribute byte. It then turns the pattern number into a position inside the shared 256-pixel-wide graphics bitmap and produces the start address of each of the pattern's 16 pixel rows.

Sprite and background graphics share one packed bitmap. Each bitmap line is 128 bytes long, and two neighbouring pixels share one byte. Sprite patterns are 16x16 pixels and sit sixteen to a band of 16 lines. A coarse base input moves the sprite area in steps of 128 lines, so everything below that base is left to 8x8 background tiles. Downstream logic receives one beat per pattern row, with the descriptor fields held steady across the 16 beats.

Top module: `sprite_fetch`

## Requirements
- R1: While reset is held, and in the first cycle after release, `memReq`, `outValid` and `done` are low.
- R2: A start pulse while idle makes the block read descriptors 0 to 124 in order. For each descriptor it reads the bytes at `0x3FE00 + 4*entry + k` for k = 0, 1, 2, 3 in that order, and each request lasts exactly one cycle.
- R3: Only one read is in flight at a time. A request is raised in the cycle after start, or in the cycle after the valid data of the previous non-final byte, and never while data is still awaited.
- R4: The bytes read are taken as k=0 vertical position (`outY`), k=1 pattern number, k=2 horizontal position (`outX`) and k=3 attribute (`outAttr`). They are shown unchanged during that descriptor's beats.
- R5: In the cycle after the fourth byte's valid data, `outValid` is high for 16 consecutive cycles, with `outRow` counting 0 to 15.
- R6: With pattern p, base b and row r, `outRowAddr = (b*128 + (p/16)*16 + r)*128 + (p%16)*8`. The base is the value of `genOffset` sampled with the start pulse; later changes have no effect until the next pass.
- R7: Row addresses are 19 bits wide and wrap modulo 2^19 when the formula exceeds 512 KB.
- R8: In the cycle after the 16th beat of descriptor 124, `done` is high for one cycle. The block then stays idle with no requests and no beats.
- R9: A start pulse during a pass is ignored, and the pass continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass over the descriptor table when idle |
| genOffset | input | 5 | Sprite area base, in units of 128 bitmap lines |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | 19 | Byte address of the read |
| memRdValid | input | 1 | Read data is valid this cycle |
| memRdData | input | 8 | Read data byte |
| outValid | output | 1 | A row beat is present |
| outRow | output | 4 | Pattern row index of the beat |
| outRowAddr | output | 19 | Start byte address of that pattern row |
| outY | output | 8 | Vertical position of the descriptor |
| outX | output | 8 | Horizontal position of the descriptor |
| outAttr | output | 8 | Attribute byte of the descriptor |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
A request is due one cycle after start, or one cycle after the valid data of a non-final byte. The first row beat is due one cycle after the fourth byte's data, and `done` is due one cycle after the last beat. The bench keeps a single "next expected event" variable, updated in the same negative-edge step that drives read data, and compares every output at the next negative edge against it. Full passes run with four read latencies and bases that include a wrapping one, so every pattern number the table holds is turned into all 16 row addresses, with the result computed arithmetically in the bench.

// File: rtl/sprite_fetch_pkg.sv
package sprite_fetch_pkg;

  localparam int FIELD_COUNT     = 4;
  localparam int FIELD_Y         = 0;
  localparam int FIELD_PAT       = 1;
  localparam int FIELD_X         = 2;
  localparam int FIELD_ATTR      = 3;
  localparam int ROWS_PER_SPRITE = 16;
  localparam int PATS_PER_BAND   = 16;
  localparam int LINE_SHIFT      = 7;   // 128 bytes per bitmap line
  localparam int BASE_SHIFT      = 7;   // offset unit is 128 lines
  localparam int BAND_SHIFT      = 4;   // 16 lines per pattern band
  localparam int COL_BYTE_SHIFT  = 3;   // 16 pixels = 8 bytes

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_EMIT,
    ST_DONE
  } fetch_state_e;

  typedef struct packed {
    logic clrEntry;
    logic incEntry;
    logic clrByte;
    logic incByte;
    logic capture;
    logic clrRow;
    logic incRow;
    logic latchOfs;
  } fetch_strobe_t;

endpackage

// File: rtl/sprite_fetch_rowaddr.sv
module sprite_fetch_rowaddr
  import sprite_fetch_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int OFS_W  = 5
) (
  input  logic [OFS_W-1:0]  baseOfs,
  input  logic [7:0]        pattern,
  input  logic [3:0]        row,
  output logic [ADDR_W-1:0] rowAddr
);

  logic [ADDR_W-1:0] lineNum;
  logic [ADDR_W-1:0] colBytes;

  // Bitmap line: base band + pattern band + row inside the pattern.
  always_comb begin
    lineNum  = (ADDR_W'(baseOfs) << BASE_SHIFT)
             + (ADDR_W'(pattern[7:4]) << BAND_SHIFT)
             + ADDR_W'(row);
    colBytes = ADDR_W'(pattern[3:0]) << COL_BYTE_SHIFT;
    rowAddr  = (lineNum << LINE_SHIFT) + colBytes;
  end

endmodule

// File: rtl/sprite_fetch_ctrl.sv
module sprite_fetch_ctrl
  import sprite_fetch_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          memRdValid,
  input  logic          lastByte,
  input  logic          lastRow,
  input  logic          lastEntry,
  output fetch_strobe_t strobe,
  output logic          memReq,
  output logic          outValid,
  output logic          done
);

  fetch_state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clrEntry = 1'b1;
          strobe.clrByte  = 1'b1;
          strobe.latchOfs = 1'b1;
          stateNext       = ST_REQ;
        end
      end
      ST_REQ: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (memRdValid) begin
          strobe.capture = 1'b1;
          if (lastByte) begin
            strobe.clrRow = 1'b1;
            stateNext     = ST_EMIT;
          end else begin
            strobe.incByte = 1'b1;
            stateNext      = ST_REQ;
          end
        end
      end
      ST_EMIT: begin
        if (!lastRow) begin
          strobe.incRow = 1'b1;
        end else if (lastEntry) begin
          stateNext = ST_DONE;
        end else begin
          strobe.incEntry = 1'b1;
          strobe.clrByte  = 1'b1;
          stateNext       = ST_REQ;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memReq   = (state == ST_REQ);
  assign outValid = (state == ST_EMIT);
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/sprite_fetch_dp.sv
module sprite_fetch_dp
  import sprite_fetch_pkg::*;
#(
  parameter int          ADDR_W      = 19,
  parameter int          OFS_W       = 5,
  parameter int          ENTRY_COUNT = 125,
  parameter logic [31:0] TABLE_BASE  = 32'h3FE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetch_strobe_t     strobe,
  input  logic [OFS_W-1:0]  genOffset,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              lastByte,
  output logic              lastRow,
  output logic              lastEntry,
  output logic [3:0]        outRow,
  output logic [ADDR_W-1:0] outRowAddr,
  output logic [7:0]        outY,
  output logic [7:0]        outX,
  output logic [7:0]        outAttr
);

  localparam int ENTRY_W  = (ENTRY_COUNT > 1) ? $clog2(ENTRY_COUNT) : 1;
  localparam int BYTE_W   = $clog2(FIELD_COUNT);
  localparam int ROW_W    = $clog2(ROWS_PER_SPRITE);

  logic [ENTRY_W-1:0] entryIdx;
  logic [BYTE_W-1:0]  byteIdx;
  logic [ROW_W-1:0]   rowIdx;
  logic [OFS_W-1:0]   baseOfs;
  logic [7:0]         fieldReg [FIELD_COUNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryIdx <= '0;
      byteIdx  <= '0;
      rowIdx   <= '0;
      baseOfs  <= '0;
    end else begin
      if (strobe.clrEntry)      entryIdx <= '0;
      else if (strobe.incEntry) entryIdx <= entryIdx + 1'b1;
      if (strobe.clrByte)       byteIdx  <= '0;
      else if (strobe.incByte)  byteIdx  <= byteIdx + 1'b1;
      if (strobe.clrRow)        rowIdx   <= '0;
      else if (strobe.incRow)   rowIdx   <= rowIdx + 1'b1;
      if (strobe.latchOfs)      baseOfs  <= genOffset;
    end
  end

  // One capture register per descriptor byte lane.
  for (genvar f = 0; f < FIELD_COUNT; f++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       fieldReg[f] <= '0;
      else if (strobe.capture && byteIdx == BYTE_W'(f)) fieldReg[f] <= memRdData;
    end
  end

  assign memAddr = ADDR_W'(TABLE_BASE)
                 + (ADDR_W'(entryIdx) << BYTE_W)
                 + ADDR_W'(byteIdx);

  assign lastByte  = (byteIdx == BYTE_W'(FIELD_COUNT - 1));
  assign lastRow   = (rowIdx == ROW_W'(ROWS_PER_SPRITE - 1));
  assign lastEntry = (entryIdx == ENTRY_W'(ENTRY_COUNT - 1));

  sprite_fetch_rowaddr #(
    .ADDR_W(ADDR_W),
    .OFS_W (OFS_W)
  ) u_rowaddr (
    .baseOfs(baseOfs),
    .pattern(fieldReg[FIELD_PAT]),
    .row    (rowIdx),
    .rowAddr(outRowAddr)
  );

  assign outRow  = rowIdx;
  assign outY    = fieldReg[FIELD_Y];
  assign outX    = fieldReg[FIELD_X];
  assign outAttr = fieldReg[FIELD_ATTR];

endmodule

// File: rtl/sprite_fetch.sv
module sprite_fetch
  import sprite_fetch_pkg::*;
#(
  parameter int          ADDR_W      = 19,
  parameter int          OFS_W       = 5,
  parameter int          ENTRY_COUNT = 125,
  parameter logic [31:0] TABLE_BASE  = 32'h3FE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OFS_W-1:0]  genOffset,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [7:0]        memRdData,
  output logic              outValid,
  output logic [3:0]        outRow,
  output logic [ADDR_W-1:0] outRowAddr,
  output logic [7:0]        outY,
  output logic [7:0]        outX,
  output logic [7:0]        outAttr,
  output logic              done
);

  fetch_strobe_t strobe;
  logic lastByte, lastRow, lastEntry;

  sprite_fetch_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memRdValid(memRdValid),
    .lastByte  (lastByte),
    .lastRow   (lastRow),
    .lastEntry (lastEntry),
    .strobe    (strobe),
    .memReq    (memReq),
    .outValid  (outValid),
    .done      (done)
  );

  sprite_fetch_dp #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .ENTRY_COUNT(ENTRY_COUNT),
    .TABLE_BASE (TABLE_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .genOffset (genOffset),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .lastByte  (lastByte),
    .lastRow   (lastRow),
    .lastEntry (lastEntry),
    .outRow    (outRow),
    .outRowAddr(outRowAddr),
    .outY      (outY),
    .outX      (outX),
    .outAttr   (outAttr)
  );

endmodule

// File: rtl/sprite_fetch_checker.sv
module sprite_fetch_checker #(
  parameter int          ADDR_W      = 19,
  parameter int          ENTRY_COUNT = 125,
  parameter logic [31:0] TABLE_BASE  = 32'h3FE00
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic              outValid,
  input logic [3:0]        outRow,
  input logic [ADDR_W-1:0] outRowAddr,
  input logic              done
);

  logic awaitData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           awaitData <= 1'b0;
    else if (memReq)     awaitData <= 1'b1;
    else if (memRdValid) awaitData <= 1'b0;
  end

  p_req_in_table_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (32'(memAddr) >= TABLE_BASE) && (32'(memAddr) < TABLE_BASE + 32'(4 * ENTRY_COUNT)));

  p_req_one_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  p_single_outstanding_r3: assert property (@(posedge clk) disable iff (!rstN)
    awaitData |-> !memReq);

  p_row_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRow != 4'd15) |=> (outValid && outRow == $past(outRow) + 4'd1));

  p_row_stride_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRow != 4'd15) |=> (outRowAddr == ADDR_W'($past(outRowAddr) + 128)));

  p_done_alone_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memReq && !outValid));

  p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!memReq && !outValid && !done));

endmodule

bind sprite_fetch sprite_fetch_checker #(
  .ADDR_W     (ADDR_W),
  .ENTRY_COUNT(ENTRY_COUNT),
  .TABLE_BASE (TABLE_BASE)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memRdValid(memRdValid),
  .outValid  (outValid),
  .outRow    (outRow),
  .outRowAddr(outRowAddr),
  .done      (done)
);

// File: tb/sprite_fetch_bench.sv
`timescale 1ns/1ps
module sprite_fetch_bench;

  localparam int ADDR_W      = 19;
  localparam int OFS_W       = 5;
  localparam int ENTRY_COUNT = 125;
  localparam int TBL         = 'h3FE00;
  localparam int MAX_CYCLES  = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [OFS_W-1:0]  genOffset = '0;
  logic              memRdValid = 1'b0;
  logic [7:0]        memRdData = '0;
  logic              memReq, outValid, done;
  logic [ADDR_W-1:0] memAddr, outRowAddr;
  logic [3:0]        outRow;
  logic [7:0]        outY, outX, outAttr;

  always #2 clk = ~clk;

  sprite_fetch u_sprite_fetch (
    .clk(clk), .rstN(rstN), .start(start), .genOffset(genOffset),
    .memReq(memReq), .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .outValid(outValid), .outRow(outRow), .outRowAddr(outRowAddr),
    .outY(outY), .outX(outX), .outAttr(outAttr), .done(done)
  );

  typedef enum int {X_IDLE, X_REQ, X_WAIT, X_BEAT, X_DONE} exp_e;

  int   checks = 0, errors = 0, cycles = 0;
  int   memLat = 0, latOfs = 0, expEntry = 0, expByte = 0, beatIdx = 0, cnt = 0, reqAddr = 0;
  bit   pending = 0, doneSeen = 0;
  exp_e nextExp = X_IDLE;
  logic [7:0] expF [4];

  function automatic logic [7:0] memByte(int a);
    return 8'((a * 13) ^ (a >> 5) ^ 7);
  endfunction

  function automatic int rawRowAddr(int ofs, int p, int r);
    return (ofs * 128 + (p / 16) * 16 + r) * 128 + (p % 16) * 8;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One cycle: wait for the falling edge, check outputs, then model memory.
  task automatic tick();
    @(negedge clk);
    cycles++;
    memRdValid = 1'b0;
    case (nextExp)
      X_IDLE: chk(!memReq && !outValid && !done, "R8 idle quiet", {memReq, outValid, done}, 0);
      X_WAIT: chk(!memReq && !outValid && !done, "R3 no request while waiting", {memReq, outValid, done}, 0);
      X_REQ: begin
        chk(memReq && !outValid && !done, "R3 request due", {memReq, outValid, done}, 4);
        chk(int'(memAddr) == TBL + 4 * expEntry + expByte, "R2 read address", memAddr,
            TBL + 4 * expEntry + expByte);
        pending = 1;
        cnt     = memLat;
        reqAddr = TBL + 4 * expEntry + expByte;
        nextExp = X_WAIT;
      end
      X_BEAT: begin
        int raw;
        raw = rawRowAddr(latOfs, expF[1], beatIdx);
        chk(outValid && !memReq, "R5 beat present", {outValid, memReq}, 2);
        chk(outRow == 4'(beatIdx), "R5 row index", outRow, beatIdx);
        chk(outY == expF[0] && outX == expF[2] && outAttr == expF[3], "R4 fields",
            {outY, outX, outAttr}, {expF[0], expF[2], expF[3]});
        if (raw >= 524288)
          chk(int'(outRowAddr) == raw % 524288, "R7 wrapped row address", outRowAddr, raw % 524288);
        else
          chk(int'(outRowAddr) == raw, "R6 row address", outRowAddr, raw);
        beatIdx++;
        if (beatIdx == 16) begin
          beatIdx = 0;
          if (expEntry == ENTRY_COUNT - 1) nextExp = X_DONE;
          else begin
            expEntry++;
            expByte = 0;
            nextExp = X_REQ;
          end
        end
      end
      X_DONE: begin
        chk(done && !memReq && !outValid, "R8 done pulse", {done, memReq, outValid}, 4);
        doneSeen = 1;
        nextExp  = X_IDLE;
      end
      default: ;
    endcase
    if (pending && nextExp == X_WAIT && !(cnt == memLat && memReq)) begin
      if (cnt == 0) begin
        memRdValid = 1'b1;
        memRdData  = memByte(reqAddr);
        expF[expByte] = memByte(reqAddr);
        pending = 0;
        if (expByte == 3) begin
          beatIdx = 0;
          nextExp = X_BEAT;
        end else begin
          expByte++;
          nextExp = X_REQ;
        end
      end else cnt--;
    end
  endtask

  task automatic runPass(int ofs, int lat, bit disturb);
    int i;
    memLat    = lat;
    genOffset = OFS_W'(ofs);
    start     = 1'b1;
    latOfs    = ofs;
    expEntry  = 0;
    expByte   = 0;
    doneSeen  = 0;
    nextExp   = X_REQ;
    tick();
    start = 1'b0;
    // the first tick above already checked the request; keep going
    i = 0;
    while (!doneSeen && cycles < MAX_CYCLES) begin
      if (disturb && i == 300) begin
        start     = 1'b1;                   // R9: ignored while busy
        genOffset = OFS_W'(ofs ^ 5'h1B);    // R6: later base changes ignored
      end
      if (disturb && i == 301) start = 1'b0;
      tick();
      i++;
    end
    start = 1'b0;
    if (!doneSeen) chk(0, "R8 watchdog expired", cycles, MAX_CYCLES);
    for (int k = 0; k < 5; k++) tick();
  endtask

  initial begin
    nextExp = X_IDLE;
    repeat (3) @(negedge clk);
    chk(!memReq && !outValid && !done, "R1 reset state", {memReq, outValid, done}, 0);
    rstN = 1'b1;
    tick();
    chk(!memReq && !outValid && !done, "R1 after release", {memReq, outValid, done}, 0);
    runPass(4, 0, 0);
    runPass(0, 1, 1);
    runPass(31, 2, 0);
    runPass(17, 3, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule